// File: doc/BRIEF.md
# PS/2 Host Register Interface

This block sits between a host bus and two serial keyboard/pointer channels and acts as the controller that software talks to. The host reaches it with single-byte reads and writes at two addresses. Address 0 is the data port. Address 1 returns a status byte when read and accepts a controller command when written. The names of the two one-byte buffers follow the device's point of view. The output buffer carries bytes toward the host. The input buffer carries a host byte on its way to a device.

The block runs the controller command set. It reads and writes a small scratch RAM whose byte 0 is the configuration byte. It enables and disables the two channels, runs self-tests and reports fixed result codes, reads and writes an output port register, and loops host bytes back into the output buffer. It can also steer the next byte to the second device, and it drives four active-low lines for a timed, masked pulse. Each channel is a byte handshake: a valid/ready pair toward the host and a valid/ready pair toward the device. Per-line fault flags can be injected for the interface tests. A byte that arrives from a channel raises a one-cycle interrupt strobe for that channel, but only when the configuration byte enables it.

Top module: `kbc_host_regs`

## Requirements
- R1: A registered read returns its byte one cycle after `host_rd`: address 0 gives the output buffer and address 1 gives the status byte. A data-port read clears status bit 0 unless a new byte is loaded in the same cycle.
- R2: The status byte is laid out as follows. Bit 0 is set while the output buffer is full. Bit 1 is set while a host byte waits for a device. Bit 2 copies configuration bit 2. Bit 3 is 1 if the last host write went to address 1 and 0 if it went to address 0. Bit 4 reads 0. Bit 5 is set while the output buffer is full with a second-channel byte. Bit 6 follows `err_timeout` and bit 7 follows `err_parity`.
- R3: Command 0x20+n (n in 0..31) places RAM byte n in the output buffer. Command 0x60+n stores the next data-port byte to RAM byte n. Byte 0 is the configuration byte, and its bits 3 and 7 always read 0.
- R4: The configuration byte uses bit 4 to disable the first channel and bit 5 to disable the second. Commands 0xAD and 0xA7 set these bits, and 0xAE and 0xA8 clear them. A channel whose bit is set never sees `dev_rx_ready` asserted.
- R5: Command 0xAA returns 0x55, or 0xFC while `ctl_fault` is high. Commands 0xAB (first channel, `port_fault[3:0]`) and 0xA9 (second channel, `port_fault[7:4]`) return 0x00 when no fault flag is set. Otherwise they return 0x01, 0x02, 0x03 or 0x04 for clock-low, clock-high, data-low or data-high, which are flag bits 0 to 3, and the lowest set bit wins.
- R6: Command 0xD1 writes the next data-port byte to `out_port`, and command 0xD0 returns `out_port`. The reset value is 0x01.
- R7: Commands 0xD2 and 0xD3 load the next data-port byte into the output buffer as if it came from the first or the second channel. This includes status bit 5 and the interrupt strobe.
- R8: A data-port write with no two-byte command pending goes to the first device, and after 0xD4 it goes to the second device. `dev_tx_valid` and `dev_tx_data` then hold steady until `dev_tx_ready`.
- R9: A byte taken from channel 1 or 2 pulses `irq_kbd` or `irq_aux` for one cycle, only when configuration bit 0 or bit 1 is set.
- R10: Command 0xF0+m drives low, for PULSE_CYC cycles, each `line_pulse_n` bit whose mask bit in m is 0. Bit 0 is the system reset line. A pulse command that arrives while a pulse is running is ignored.
- R11: While the output buffer is full, neither channel is offered `dev_rx_ready`, so a pending device byte is never overwritten. The first channel wins when both channels offer a byte.
- R12: A command code that is not listed above leaves the configuration byte, the output buffer, the output port and the pulse lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = data port, 1 = status/command port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| dev_rx_valid | input | 2 | Per channel: device byte available |
| dev_rx_data | input | 16 | Device bytes, channel 1 in [7:0] |
| dev_rx_ready | output | 2 | Per channel: byte is taken this cycle when valid |
| dev_tx_valid | output | 2 | Per channel: host byte waiting for the device |
| dev_tx_data | output | 8 | Host byte toward a device |
| dev_tx_ready | input | 2 | Per channel: device takes the byte |
| port_fault | input | 8 | Injected line faults, channel 1 in [3:0] |
| ctl_fault | input | 1 | Forces the controller self-test to fail |
| err_timeout | input | 1 | Time-out error flag for status bit 6 |
| err_parity | input | 1 | Parity error flag for status bit 7 |
| irq_kbd | output | 1 | First-channel interrupt strobe |
| irq_aux | output | 1 | Second-channel interrupt strobe |
| out_port | output | 8 | Output port register |
| line_pulse_n | output | 4 | Active-low pulse lines, bit 0 is reset |

## Verification
A corrupted configuration byte is visible at the ports in the same cycle, because `dev_rx_ready` is gated by it, and a 0x20 read-back shows it two cycles after the command. A stale pending-command state shows up on the next data-port write: the byte goes to the wrong device, or into the output buffer, instead of where the bench expects it. A wrong output-buffer flag shows at the next status read, and a device byte that should be held off is accepted early and then appears at the data port out of order.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  typedef enum logic [2:0] {
    PD_NONE,
    PD_RAM,
    PD_OUTP,
    PD_OB1,
    PD_OB2,
    PD_DEV2
  } pend_t;

  localparam logic [7:0] CFG_KEEP  = 8'h77;
  localparam logic [7:0] ST_PASS   = 8'h55;
  localparam logic [7:0] ST_FAIL   = 8'hFC;

  // fault flags: [0] clock low, [1] clock high, [2] data low, [3] data high
  function automatic logic [7:0] line_diag(input logic [3:0] f);
    if (f[0])      return 8'h01;
    else if (f[1]) return 8'h02;
    else if (f[2]) return 8'h03;
    else if (f[3]) return 8'h04;
    else           return 8'h00;
  endfunction

endpackage

// File: rtl/kbc_scratch_ram.sv
module kbc_scratch_ram #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/kbc_rx_arb.sv
module kbc_rx_arb #(
  parameter int NCH = 2,
  parameter int DW  = 8
) (
  input  logic [NCH-1:0]    rx_valid,
  input  logic [NCH*DW-1:0] rx_data,
  input  logic [NCH-1:0]    port_en,
  input  logic              allow,
  output logic [NCH-1:0]    rx_ready,
  output logic              take,
  output logic              take_ch,
  output logic [DW-1:0]     take_data
);
  logic [NCH-1:0] offer;

  assign offer = rx_valid & port_en;

  // fixed priority: lower channel index first
  always_comb begin
    rx_ready = '0;
    if (allow) begin
      rx_ready[0] = port_en[0];
      rx_ready[1] = port_en[1] & ~offer[0];
    end
  end

  assign take      = |(rx_valid & rx_ready);
  assign take_ch   = ~(rx_valid[0] & rx_ready[0]);
  assign take_data = take_ch ? rx_data[2*DW-1:DW] : rx_data[DW-1:0];
endmodule

// File: rtl/kbc_line_pulse.sv
module kbc_line_pulse #(
  parameter int PULSE_CYC = 750000,
  parameter int NL        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NL-1:0] mask,
  output logic [NL-1:0] lines_n,
  output logic          busy
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_n <= '1;
      busy    <= 1'b0;
      cnt     <= '0;
    end else if (busy) begin
      if (cnt == CW'(PULSE_CYC - 1)) begin
        lines_n <= '1;
        busy    <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start && (mask != '1)) begin
      lines_n <= mask;
      busy    <= 1'b1;
      cnt     <= '0;
    end
  end

  a_r10_width_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(cnt) < PULSE_CYC));
  a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (lines_n == '1));
  a_r10_hold_mask: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(lines_n));
endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_pkg::*;
#(
  parameter int         RAM_AW     = 5,
  parameter int         PULSE_CYC  = 750000,
  parameter logic [7:0] OUTP_RESET = 8'h01
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic [1:0]  dev_rx_valid,
  input  logic [15:0] dev_rx_data,
  output logic [1:0]  dev_rx_ready,
  output logic [1:0]  dev_tx_valid,
  output logic [7:0]  dev_tx_data,
  input  logic [1:0]  dev_tx_ready,
  input  logic [7:0]  port_fault,
  input  logic        ctl_fault,
  input  logic        err_timeout,
  input  logic        err_parity,
  output logic        irq_kbd,
  output logic        irq_aux,
  output logic [7:0]  out_port,
  output logic [3:0]  line_pulse_n
);
  localparam int NCH = 2;
  localparam int DW  = 8;
  localparam int NL  = 4;

  // state
  logic [DW-1:0]     cfg;
  logic [DW-1:0]     obuf;
  logic              obf;
  logic              ob_aux;
  logic              cmd_flag;
  pend_t             pend;
  logic [RAM_AW-1:0] pidx;
  logic              resp_v;
  logic              resp_ram;
  logic [DW-1:0]     resp_imm;
  logic [NCH-1:0]    tx_v;
  logic [DW-1:0]     tx_d;
  logic [NCH-1:0]    irq_q;
  logic [DW-1:0]     status;

  // decoded strobes
  logic wr_cmd, wr_dat, pulse_go, pulse_busy;
  logic ram_we;
  logic [DW-1:0] ram_q;
  logic rx_take, rx_ch, rx_allow;
  logic [DW-1:0] rx_byte;

  assign wr_cmd   = host_wr &  host_addr;
  assign wr_dat   = host_wr & ~host_addr;
  assign pulse_go = wr_cmd & (host_wdata[7:4] == 4'hF);
  assign ram_we   = wr_dat & (pend == PD_RAM) & (pidx != '0);
  assign rx_allow = ~obf & ~resp_v & ~host_wr & ~host_rd;

  assign status = {err_parity, err_timeout, obf & ob_aux, 1'b0,
                   cmd_flag, cfg[2], |tx_v, obf};

  kbc_scratch_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (pidx),
    .wdata (host_wdata),
    .raddr (host_wdata[RAM_AW-1:0]),
    .rdata (ram_q)
  );

  kbc_rx_arb #(.NCH(NCH), .DW(DW)) u_arb (
    .rx_valid  (dev_rx_valid),
    .rx_data   (dev_rx_data),
    .port_en   (~cfg[5:4]),
    .allow     (rx_allow),
    .rx_ready  (dev_rx_ready),
    .take      (rx_take),
    .take_ch   (rx_ch),
    .take_data (rx_byte)
  );

  kbc_line_pulse #(.PULSE_CYC(PULSE_CYC), .NL(NL)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .start   (pulse_go),
    .mask    (host_wdata[NL-1:0]),
    .lines_n (line_pulse_n),
    .busy    (pulse_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg        <= '0;
      obuf       <= '0;
      obf        <= 1'b0;
      ob_aux     <= 1'b0;
      cmd_flag   <= 1'b0;
      pend       <= PD_NONE;
      pidx       <= '0;
      resp_v     <= 1'b0;
      resp_ram   <= 1'b0;
      resp_imm   <= '0;
      tx_v       <= '0;
      tx_d       <= '0;
      irq_q      <= '0;
      out_port   <= OUTP_RESET;
      host_rdata <= '0;
    end else begin
      irq_q  <= '0;
      resp_v <= 1'b0;

      for (int i = 0; i < NCH; i++) begin
        if (tx_v[i] && dev_tx_ready[i]) tx_v[i] <= 1'b0;
      end

      if (host_rd) begin
        host_rdata <= host_addr ? status : obuf;
        if (!host_addr) obf <= 1'b0;
      end

      if (resp_v) begin
        obuf   <= resp_ram ? ram_q : resp_imm;
        obf    <= 1'b1;
        ob_aux <= 1'b0;
      end

      if (rx_take) begin
        obuf         <= rx_byte;
        obf          <= 1'b1;
        ob_aux       <= rx_ch;
        irq_q[rx_ch] <= cfg[rx_ch];
      end

      if (host_wr) begin
        cmd_flag <= host_addr;
        pend     <= PD_NONE;
        if (host_addr) begin
          casez (host_wdata)
            8'b001?_????: begin
              resp_v <= 1'b1;
              if (host_wdata[4:0] == 5'd0) begin
                resp_ram <= 1'b0;
                resp_imm <= cfg;
              end else begin
                resp_ram <= 1'b1;
              end
            end
            8'b011?_????: begin
              pend <= PD_RAM;
              pidx <= host_wdata[RAM_AW-1:0];
            end
            8'hA7: cfg[5] <= 1'b1;
            8'hA8: cfg[5] <= 1'b0;
            8'hAD: cfg[4] <= 1'b1;
            8'hAE: cfg[4] <= 1'b0;
            8'hA9: begin
              resp_v <= 1'b1; resp_ram <= 1'b0;
              resp_imm <= line_diag(port_fault[7:4]);
            end
            8'hAB: begin
              resp_v <= 1'b1; resp_ram <= 1'b0;
              resp_imm <= line_diag(port_fault[3:0]);
            end
            8'hAA: begin
              resp_v <= 1'b1; resp_ram <= 1'b0;
              resp_imm <= ctl_fault ? ST_FAIL : ST_PASS;
            end
            8'hD0: begin
              resp_v <= 1'b1; resp_ram <= 1'b0;
              resp_imm <= out_port;
            end
            8'hD1: pend <= PD_OUTP;
            8'hD2: pend <= PD_OB1;
            8'hD3: pend <= PD_OB2;
            8'hD4: pend <= PD_DEV2;
            default: ;
          endcase
        end else begin
          case (pend)
            PD_RAM: begin
              if (pidx == '0) cfg <= host_wdata & CFG_KEEP;
            end
            PD_OUTP: out_port <= host_wdata;
            PD_OB1, PD_OB2: begin
              obuf   <= host_wdata;
              obf    <= 1'b1;
              ob_aux <= (pend == PD_OB2);
              if (pend == PD_OB2) irq_q[1] <= cfg[1];
              else                irq_q[0] <= cfg[0];
            end
            PD_DEV2: begin
              tx_v[1] <= 1'b1;
              tx_d    <= host_wdata;
            end
            default: begin
              tx_v[0] <= 1'b1;
              tx_d    <= host_wdata;
            end
          endcase
        end
      end
    end
  end

  assign dev_tx_valid = tx_v;
  assign dev_tx_data  = tx_d;
  assign irq_kbd      = irq_q[0];
  assign irq_aux      = irq_q[1];

  // R11: a full output buffer holds off both channels
  a_r11_hold_off: assert property (@(posedge clk) disable iff (rst)
    obf |-> (dev_rx_ready == 2'b00));
  // R4: a disabled channel is never offered ready
  a_r4_gate_first: assert property (@(posedge clk) disable iff (rst)
    cfg[4] |-> !dev_rx_ready[0]);
  a_r4_gate_second: assert property (@(posedge clk) disable iff (rst)
    cfg[5] |-> !dev_rx_ready[1]);
  // R1: data read empties the buffer when nothing reloads it
  a_r1_read_clears: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_addr && !resp_v && !host_wr) |=> !obf);
  // R9: interrupt strobes are single cycle and accompany a full buffer
  a_r9_irq_single: assert property (@(posedge clk) disable iff (rst)
    (irq_kbd || irq_aux) |=> !(irq_kbd || irq_aux));
  a_r9_irq_with_data: assert property (@(posedge clk) disable iff (rst)
    irq_aux |-> (obf && ob_aux));
  // R8: a waiting host byte stays put until the device takes it
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_v[0] && !dev_tx_ready[0] && !host_wr) |=> (tx_v[0] && $stable(tx_d)));
  // R10: a pulse command while busy does not reload the lines
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (pulse_busy && pulse_go) |=> $stable(line_pulse_n) || (line_pulse_n == '1));
endmodule

// File: tb/kbc_host_regs_test.sv
`timescale 1ns/1ps
module kbc_host_regs_test;
  localparam int PC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [1:0]  dev_rx_valid = '0;
  logic [15:0] dev_rx_data = '0;
  logic [1:0]  dev_rx_ready;
  logic [1:0]  dev_tx_valid;
  logic [7:0]  dev_tx_data;
  logic [1:0]  dev_tx_ready = '0;
  logic [7:0]  port_fault = '0;
  logic        ctl_fault = 1'b0, err_timeout = 1'b0, err_parity = 1'b0;
  logic        irq_kbd, irq_aux;
  logic [7:0]  out_port;
  logic [3:0]  line_pulse_n;

  int checks = 0;
  int errors = 0;
  int irq1_cnt = 0;
  int irq12_cnt = 0;
  logic rd_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  kbc_host_regs #(.PULSE_CYC(PC)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data),
    .dev_rx_ready(dev_rx_ready), .dev_tx_valid(dev_tx_valid),
    .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
    .port_fault(port_fault), .ctl_fault(ctl_fault),
    .err_timeout(err_timeout), .err_parity(err_parity),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux), .out_port(out_port),
    .line_pulse_n(line_pulse_n)
  );

  always @(posedge clk) rd_d <= host_rd;

  // monitor: compare each returned read byte with the scoreboard
  always @(negedge clk) begin
    if (irq_kbd) irq1_cnt++;
    if (irq_aux) irq12_cnt++;
    if (rd_d) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty actual %h expected none", host_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, host_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    idle(2);
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic finish_dev(input int ch);
    #1;
    forever begin
      if (dev_rx_ready[ch]) begin
        @(negedge clk);
        dev_rx_valid[ch] = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send_dev(input int ch, input logic [7:0] b);
    dev_rx_data[ch*8 +: 8] = b;
    dev_rx_valid[ch] = 1'b1;
    finish_dev(ch);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    // reset state
    chk("R10 reset lines", line_pulse_n, 4'hF);
    chk("R6 reset out_port", out_port, 8'h01);
    chk("R4 reset ready", dev_rx_ready, 2'b11);
    chk("R8 reset tx", dev_tx_valid, 2'b00);
    rd(1, 8'h00, "R2 reset status");

    // R3 scratch RAM write and read
    wr(1, 8'h65); wr(0, 8'hA5); wr(1, 8'h25);
    rd(0, 8'hA5, "R3 ram byte 5");
    rd(1, 8'h08, "R1 read cleared obf");

    // R3 config mask, R2 system flag
    wr(1, 8'h60); wr(0, 8'hFF);
    chk("R4 both disabled", dev_rx_ready, 2'b00);
    wr(1, 8'h20);
    rd(1, 8'h0D, "R2 obf sysflag cmd");
    rd(0, 8'h77, "R3 cfg masked");

    // R4 enable/disable
    wr(1, 8'hAE);
    chk("R4 first enabled", dev_rx_ready, 2'b01);
    wr(1, 8'h20);
    rd(0, 8'h67, "R4 cfg after AE");
    wr(1, 8'hA8);
    wr(1, 8'hAD);
    chk("R4 first disabled", dev_rx_ready, 2'b10);
    wr(1, 8'hAE);
    chk("R4 both enabled", dev_rx_ready, 2'b11);

    // irqs on
    wr(1, 8'h60); wr(0, 8'h03);

    // R11 back-pressure and priority, R9 strobes
    send_dev(0, 8'h1C);
    idle(1);
    chk("R9 irq1 count", irq1_cnt, 1);
    rd(1, 8'h01, "R2 first channel byte");
    dev_rx_data[15:8] = 8'h77;
    dev_rx_valid[1] = 1'b1;
    idle(3);
    chk("R11 held off", dev_rx_ready, 2'b00);
    rd(0, 8'h1C, "R11 first byte kept");
    finish_dev(1);
    idle(1);
    rd(1, 8'h21, "R2 second channel flag");
    chk("R9 irq12 count", irq12_cnt, 1);
    rd(0, 8'h77, "R11 second byte after drain");

    // R9 gated off
    wr(1, 8'h60); wr(0, 8'h00);
    send_dev(0, 8'h2A);
    idle(1);
    chk("R9 irq1 gated", irq1_cnt, 1);
    rd(0, 8'h2A, "R9 byte still delivered");

    // R7 loopback
    wr(1, 8'h60); wr(0, 8'h03);
    wr(1, 8'hD2); wr(0, 8'h3C);
    chk("R7 loop irq1", irq1_cnt, 2);
    rd(1, 8'h01, "R7 loop first status");
    rd(0, 8'h3C, "R7 loop first data");
    wr(1, 8'hD3); wr(0, 8'h4D);
    rd(1, 8'h21, "R7 loop second status");
    chk("R7 loop irq12", irq12_cnt, 2);
    rd(0, 8'h4D, "R7 loop second data");

    // R6 output port
    wr(1, 8'hD1); wr(0, 8'h5B);
    chk("R6 out_port written", out_port, 8'h5B);
    wr(1, 8'hD0);
    rd(0, 8'h5B, "R6 out_port read");

    // R5 self tests
    wr(1, 8'hAA); rd(0, 8'h55, "R5 ctl pass");
    ctl_fault = 1'b1;
    wr(1, 8'hAA); rd(0, 8'hFC, "R5 ctl fail");
    ctl_fault = 1'b0;
    port_fault = 8'h08;
    wr(1, 8'hAB); rd(0, 8'h04, "R5 first data high");
    port_fault = 8'h50;
    wr(1, 8'hA9); rd(0, 8'h01, "R5 second priority");
    wr(1, 8'hAB); rd(0, 8'h00, "R5 first pass");
    port_fault = 8'h00;

    // R8 host bytes toward devices
    wr(0, 8'hED);
    chk("R8 first valid", dev_tx_valid, 2'b01);
    chk("R8 first data", dev_tx_data, 8'hED);
    rd(1, 8'h02, "R2 input buffer full");
    dev_tx_ready = 2'b01;
    idle(2);
    chk("R8 first drained", dev_tx_valid, 2'b00);
    dev_tx_ready = 2'b00;
    wr(1, 8'hD4); wr(0, 8'hF4);
    chk("R8 second valid", dev_tx_valid, 2'b10);
    chk("R8 second data", dev_tx_data, 8'hF4);
    dev_tx_ready = 2'b10;
    idle(2);
    chk("R8 second drained", dev_tx_valid, 2'b00);
    dev_tx_ready = 2'b00;

    // R12 unlisted commands
    wr(1, 8'hC5); wr(1, 8'h9E);
    rd(1, 8'h08, "R12 no output byte");
    chk("R12 out_port kept", out_port, 8'h5B);
    chk("R12 lines kept", line_pulse_n, 4'hF);
    wr(1, 8'h20);
    rd(0, 8'h03, "R12 cfg kept");

    // R2 error bits
    err_timeout = 1'b1; err_parity = 1'b1;
    rd(1, 8'hC8, "R2 error bits");
    err_timeout = 1'b0; err_parity = 1'b0;

    // R10 pulse: reset line only, second command ignored
    wr(1, 8'hFE);
    chk("R10 reset low", line_pulse_n, 4'hE);
    wr(1, 8'hF7);
    chk("R10 busy ignore", line_pulse_n, 4'hE);
    idle(PC - 6);
    chk("R10 last low cycle", line_pulse_n, 4'hE);
    idle(1);
    chk("R10 released", line_pulse_n, 4'hF);

    idle(3);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule